// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter Stage

This block is a small binary counter with two separate count strobes: one that steps the value up and one that steps it down. It can be loaded from a parallel data word, cleared by a master clear, and reports the two terminal conditions on active-low carry and borrow outputs. Those two outputs are shaped so that they can feed the count strobes of an identical stage directly. A chain of stages therefore forms a wider counter with no glue logic.

The whole block runs on one free-running system clock. Each strobe passes through a synchronizer, and a step is recognised when the synchronized level rises. Clear and load are level-sensitive overrides that are sampled on the system clock. Carry goes low while the count sits at its top value and the synchronized up strobe is low. Borrow goes low while the count is zero and the synchronized down strobe is low. In each case the output rises again on the same strobe edge that makes the count wrap. The next stage sees that rising output as its own count edge.

Top module: `updn_counter4`

## Requirements
- R1: While the synchronous system reset `rst_n` is low, the count is forced to 0 on each clock edge and both `carry_n` and `borrow_n` are driven high.
- R2: While `clr` is high, the count becomes 0 on the next clock edge. Clear wins over a low `load_n` and over any strobe edge.
- R3: While `clr` is low and `load_n` is low, the count takes the value of `din` on the next clock edge. Load wins over any strobe edge.
- R4: A rising edge of `up_clk` while `dn_clk` is high adds one to the count. The maximum value (all ones) wraps to 0.
- R5: A rising edge of `dn_clk` while `up_clk` is high subtracts one from the count. The value 0 wraps to the maximum value.
- R6: A rising edge on one strobe while the other strobe is low leaves the count unchanged.
- R7: A strobe edge that is recognised while `clr` is high or `load_n` is low is discarded. It does not act once the override is released.
- R8: `carry_n` is low exactly while the count is at its maximum and the synchronized `up_clk` level is low. Otherwise it is high.
- R9: `borrow_n` is low exactly while the count is 0 and the synchronized `dn_clk` level is low. Otherwise it is high.
- R10: With the default two synchronizer stages, a qualifying strobe rise changes the count on the third system clock edge after it. The count is unchanged after the first and second edges.
- R11: If both strobes rise in the same system clock cycle, the count does not change.
- R12: Two stages form an 8-bit counter when `carry_n` of the low stage drives `up_clk` of the high stage and `borrow_n` drives `dn_clk`. The pair then counts up through 255→0 and down through 0→255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Master clear, active high, level-sensitive |
| load_n | input | 1 | Parallel load enable, active low, level-sensitive |
| din | input | 4 | Value loaded while `load_n` is low |
| up_clk | input | 1 | Count-up strobe; counts on its rising edge |
| dn_clk | input | 1 | Count-down strobe; counts on its rising edge |
| q | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count in the up direction |
| borrow_n | output | 1 | Active-low terminal count in the down direction |

## Verification
The assertions assume that each strobe holds its level for several system clock cycles between transitions, so that no pulse is lost in the synchronizer. They also assume that `din` is stable around the cycle in which a load is taken. The stimulus holds every strobe phase for at least six system clocks. It changes data and override inputs only on the falling clock edge. In the chained pair, this gives the low stage's carry and borrow a low phase long enough for the high stage to synchronize. The step assertion relies on the strobes being idle-high, so that any count change outside clear and load comes from a single up or down step.

// File: rtl/counter_pkg.sv
// Package: shared operation type for the dual-strobe counter.
// Assumes nothing beyond the set of operations the counter register can apply.
package counter_pkg;

    // One operation is applied to the count register per system clock.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } cnt_op_e;

endpackage : counter_pkg

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Brings one asynchronous strobe into the system clock domain through a
// chain of STAGES flops. It reports the synchronized level and a one-cycle
// pulse when that level rises.
// Assumes the strobe stays at each level for longer than STAGES clocks.
// The strobes idle high, so the chain resets to ones.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              level_d;

    // Shift the raw strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b1;
        end else begin
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~level_d;

endmodule : strobe_sync

// File: rtl/op_decode.sv
// Module: op_decode
// Picks the single operation for this cycle. Clear wins over load, and load
// wins over counting. A count edge qualifies only while the opposite strobe
// is high. Edges from both strobes in the same cycle cancel out.
// Assumes level and rise inputs come from strobe_sync.
module op_decode
    import counter_pkg::*;
(
    input  logic    clr,
    input  logic    load_n,
    input  logic    up_rise,
    input  logic    dn_rise,
    input  logic    up_lvl,
    input  logic    dn_lvl,
    output cnt_op_e op
);

    logic up_ok;
    logic dn_ok;

    assign up_ok = up_rise & dn_lvl;
    assign dn_ok = dn_rise & up_lvl;

    // Resolve the priority between overrides and the two count directions.
    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (up_ok && !dn_ok) begin
            op = OP_INC;
        end else if (dn_ok && !up_ok) begin
            op = OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule : op_decode

// File: rtl/count_reg.sv
// Module: count_reg
// The W-bit count register. It applies the decoded operation on each clock
// edge and wraps naturally at both ends of the range.
// Assumes op is stable before the clock edge (it is combinational from flops
// and from inputs driven away from the edge).
module count_reg
    import counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_op_e      op,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    // Update the stored count according to the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= din;
                OP_INC:   q <= q + ONE;
                OP_DEC:   q <= q - ONE;
                default:  q <= q;
            endcase
        end
    end

endmodule : count_reg

// File: rtl/term_flags.sv
// Module: term_flags
// Forms the active-low carry and borrow. Each goes low only while the count
// is at its terminal value and the matching synchronized strobe is low.
// Each rises on the same strobe edge that wraps the count, which makes it a
// clean clock for the next stage.
// Assumes the strobe levels are the synchronized ones from strobe_sync.
module term_flags #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         up_lvl,
    input  logic         dn_lvl,
    output logic         carry_n,
    output logic         borrow_n
);

    logic at_max;
    logic at_min;

    // Detect the two terminal values of the count.
    always_comb begin
        at_max = &q;
        at_min = ~|q;
    end

    // Gate each terminal flag with the low phase of its strobe.
    always_comb begin
        carry_n  = ~(at_max & ~up_lvl);
        borrow_n = ~(at_min & ~dn_lvl);
    end

endmodule : term_flags

// File: rtl/updn_counter4.sv
// Module: updn_counter4 (top)
// A presettable binary up/down counter with separate up and down strobes.
// Clear and load are level overrides. Carry and borrow are active low and
// can drive the strobes of a following stage directly.
// Assumes a free-running clk that is much faster than either strobe.
module updn_counter4
    import counter_pkg::*;
#(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         up_clk,
    input  logic         dn_clk,
    output logic [W-1:0] q,
    output logic         carry_n,
    output logic         borrow_n
);

    localparam int N_STRB = 2;
    localparam int IDX_UP = 0;
    localparam int IDX_DN = 1;

    logic [N_STRB-1:0] strb_raw;
    logic [N_STRB-1:0] strb_lvl;
    logic [N_STRB-1:0] strb_rise;
    cnt_op_e           op;

    assign strb_raw[IDX_UP] = up_clk;
    assign strb_raw[IDX_DN] = dn_clk;

    // One synchronizer and edge detector per strobe.
    for (genvar i = 0; i < N_STRB; i++) begin : g_sync
        strobe_sync #(.STAGES(STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (strb_raw[i]),
            .level    (strb_lvl[i]),
            .rise     (strb_rise[i])
        );
    end

    op_decode u_dec (
        .clr     (clr),
        .load_n  (load_n),
        .up_rise (strb_rise[IDX_UP]),
        .dn_rise (strb_rise[IDX_DN]),
        .up_lvl  (strb_lvl[IDX_UP]),
        .dn_lvl  (strb_lvl[IDX_DN]),
        .op      (op)
    );

    count_reg #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    term_flags #(.W(W)) u_term (
        .q        (q),
        .up_lvl   (strb_lvl[IDX_UP]),
        .dn_lvl   (strb_lvl[IDX_DN]),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

endmodule : updn_counter4

// File: rtl/updn_counter4_chk.sv
// Module: updn_counter4_chk
// Checker bound to every updn_counter4. It checks the port behaviour over time.
// Assumes strobes are idle-high and held for several clocks per phase.
module updn_counter4_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         carry_n,
    input logic         borrow_n
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // R1: reset forces zero count and idle terminal outputs.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (q == '0) && carry_n && borrow_n);

    // R2: clear empties the count on the next edge.
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R3: load without clear copies din.
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (q == $past(din)));

    // R4/R5: outside overrides the count moves by at most one step.
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $past(load_n) && (q != $past(q)))
        |-> ((q == $past(q) + ONE) || (q == $past(q) - ONE)));

    // R8: carry stays high away from the top value.
    a_r8_carry_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q != MAXV) |-> carry_n);

    // R9: borrow stays high away from zero.
    a_r9_borrow_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '0) |-> borrow_n);

endmodule : updn_counter4_chk

bind updn_counter4 updn_counter4_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load_n   (load_n),
    .din      (din),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/sim_updn_counter4.sv
// Bench: two chained stages form an 8-bit counter. A driver pushes expected
// items into a scoreboard queue, and a monitor compares them just after each
// falling clock edge.
module sim_updn_counter4;

    localparam int CLK_PERIOD = 10;
    localparam int PH_LOW     = 6;
    localparam int PH_HIGH    = 8;
    localparam int WATCHDOG   = 100000;

    localparam int K_COUNT8 = 0;
    localparam int K_CARRY0 = 1;
    localparam int K_BORROW0 = 2;

    typedef struct {
        int         kind;
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] din8 = 8'h00;
    logic       up = 1'b1;
    logic       dn = 1'b1;

    logic [3:0] q_lo, q_hi;
    logic       carry_lo, borrow_lo, carry_hi, borrow_hi;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_counter4 u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .din(din8[3:0]), .up_clk(up), .dn_clk(dn),
        .q(q_lo), .carry_n(carry_lo), .borrow_n(borrow_lo)
    );

    updn_counter4 u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .din(din8[7:4]), .up_clk(carry_lo), .dn_clk(borrow_lo),
        .q(q_hi), .carry_n(carry_hi), .borrow_n(borrow_hi)
    );

    // Push one expected item; the monitor checks it after this falling edge.
    task automatic expect_item(input int kind, input logic [7:0] val, input string tag);
        exp_t e;
        e.kind = kind;
        e.val  = val;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load8(input logic [7:0] v);
        @(negedge clk);
        din8   = v;
        load_n = 1'b0;
        wait_neg(2);
        load_n = 1'b1;
        wait_neg(2);
    endtask

    task automatic pulse_up();
        @(negedge clk);
        up = 1'b0;
        wait_neg(PH_LOW);
        up = 1'b1;
        wait_neg(PH_HIGH);
    endtask

    task automatic pulse_dn();
        @(negedge clk);
        dn = 1'b0;
        wait_neg(PH_LOW);
        dn = 1'b1;
        wait_neg(PH_HIGH);
    endtask

    // Monitor: pop every pending item and compare it with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t       e;
                logic [7:0] act;
                e = sb.pop_front();
                case (e.kind)
                    K_COUNT8:  act = {q_hi, q_lo};
                    K_CARRY0:  act = {7'd0, carry_lo};
                    default:   act = {7'd0, borrow_lo};
                endcase
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Driver: the stimulus sequence with expected values from the requirements.
    initial begin
        // R1: reset state
        wait_neg(4);
        expect_item(K_COUNT8, 8'h00, "R1 reset count");
        expect_item(K_CARRY0, 8'h01, "R1 reset carry");
        expect_item(K_BORROW0, 8'h01, "R1 reset borrow");
        @(negedge clk);
        rst_n = 1'b1;
        wait_neg(2);

        // R3: parallel load
        load8(8'hA7);
        expect_item(K_COUNT8, 8'hA7, "R3 load");

        // R2: clear beats load
        @(negedge clk);
        din8 = 8'h3C; load_n = 1'b0; clr = 1'b1;
        wait_neg(2);
        expect_item(K_COUNT8, 8'h00, "R2 clear over load");
        clr = 1'b0; load_n = 1'b1;
        wait_neg(2);

        // R7: edges during load and during clear are discarded
        @(negedge clk);
        din8 = 8'h5A; load_n = 1'b0;
        pulse_up();
        load_n = 1'b1;
        wait_neg(6);
        expect_item(K_COUNT8, 8'h5A, "R7 edge during load");
        clr = 1'b1;
        pulse_dn();
        clr = 1'b0;
        wait_neg(6);
        expect_item(K_COUNT8, 8'h00, "R7 edge during clear");

        // R10: latency of a qualifying up edge
        load8(8'h30);
        @(negedge clk);
        up = 1'b0;
        wait_neg(PH_LOW);
        up = 1'b1;
        @(negedge clk);
        expect_item(K_COUNT8, 8'h30, "R10 after first edge");
        @(negedge clk);
        expect_item(K_COUNT8, 8'h30, "R10 after second edge");
        @(negedge clk);
        expect_item(K_COUNT8, 8'h31, "R10 after third edge");
        wait_neg(PH_HIGH);

        // R4, R8, R12: count up through 255 -> 0
        load8(8'hFD);
        pulse_up();
        expect_item(K_COUNT8, 8'hFE, "R4 up FD->FE");
        pulse_up();
        expect_item(K_COUNT8, 8'hFF, "R4 up FE->FF");
        expect_item(K_CARRY0, 8'h01, "R8 carry high while up high");
        @(negedge clk);
        up = 1'b0;
        wait_neg(4);
        expect_item(K_CARRY0, 8'h00, "R8 carry low at max");
        wait_neg(2);
        up = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'h00, "R12 cascade wrap 255->0");
        expect_item(K_CARRY0, 8'h01, "R8 carry high after wrap");
        pulse_up();
        expect_item(K_COUNT8, 8'h01, "R4 up 00->01");

        // R5, R9, R12: count down through 0 -> 255
        load8(8'h02);
        pulse_dn();
        expect_item(K_COUNT8, 8'h01, "R5 down 02->01");
        pulse_dn();
        expect_item(K_COUNT8, 8'h00, "R5 down 01->00");
        @(negedge clk);
        dn = 1'b0;
        wait_neg(4);
        expect_item(K_BORROW0, 8'h00, "R9 borrow low at zero");
        wait_neg(2);
        dn = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'hFF, "R12 cascade wrap 0->255");
        expect_item(K_BORROW0, 8'h01, "R9 borrow high after wrap");
        pulse_dn();
        expect_item(K_COUNT8, 8'hFE, "R5 down FF->FE");

        // R6: an edge while the other strobe is low does nothing
        load8(8'h35);
        @(negedge clk);
        dn = 1'b0;
        wait_neg(PH_LOW);
        up = 1'b0;
        wait_neg(PH_LOW);
        up = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'h35, "R6 up edge with down low");
        up = 1'b0;
        wait_neg(PH_LOW);
        dn = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'h35, "R6 down edge with up low");
        up = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'h36, "R4 up edge with down high");

        // R11: simultaneous rises cancel
        @(negedge clk);
        up = 1'b0; dn = 1'b0;
        wait_neg(PH_LOW);
        up = 1'b1; dn = 1'b1;
        wait_neg(PH_HIGH);
        expect_item(K_COUNT8, 8'h36, "R11 both strobes rise together");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        wait_neg(3);
        expect_item(K_COUNT8, 8'h00, "R1 reset mid-run");
        wait_neg(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule : sim_updn_counter4